// File: doc/BRIEF.md
# Authenticated Remote Update Controller

This block runs the device end of an over-the-wire configuration update. When a session starts it first sends the server a fixed public device fingerprint and the version number of the image it currently holds. It then sends a fresh device nonce, taken from a session counter, and takes in the server's nonce and the version number of the offered image. An offered version that is not strictly newer ends the session at once. Otherwise the image bytes are written unchanged, still encrypted, to external non-volatile storage. Each byte is fed to a keyed MAC engine in the same cycle it is written.

At the end of the image the server sends a tag. If the tag equals the locally computed one, the new version is committed and the boot choice moves to the freshly written image. A mismatch, a stale version or a stalled session instead points the boot choice at the read-only default image. The MAC engine is a small behavioural stand-in behind a ready/valid handshake. The key can be written but never read.

Top module: `remote_update_ctrl`

## Requirements
- R1: After reset, cur_version is 0, boot_sel is 0 (default image), and busy, tx_valid, rx_ready, nvm_we, done_ok and done_fail are all 0.
- R2: After start is seen in idle, the first six bytes sent on tx are the 32-bit fingerprint and then the 16-bit cur_version, each field most significant byte first.
- R3: The next four tx bytes are the device nonce, most significant byte first. The nonce is a session counter that is 0 after reset and is incremented once when each session starts, so the first session sends 1.
- R4: After the device nonce, the block accepts four server-nonce bytes and then two new-version bytes (most significant first) on rx. These header bytes are accepted whatever the level of nvm_ready.
- R5: If the received new version is not strictly greater than cur_version, done_fail pulses in the cycle after the last version byte. No storage write takes place, and cur_version is left unchanged.
- R6: Otherwise the next IMG_BYTES rx bytes are written to storage unchanged, at addresses 0 upward. A byte is accepted, and nvm_we is raised, only in a cycle where nvm_ready is 1.
- R7: The tag is a 32-bit value received as four bytes, most significant first. The expected tag is formed from the key. The accumulator starts as key[31:0]. For each byte b, in the order fingerprint, current version, device nonce, server nonce, new version, image, the accumulator becomes (the accumulator rotated left by one) plus b, modulo 2^32. The final tag is the accumulator XOR key[63:32].
- R8: On a tag match, done_ok pulses for one cycle. From the next cycle on, cur_version holds the new version and boot_sel is 1. Both are updated together and only then.
- R9: On a tag mismatch, done_fail pulses for one cycle, boot_sel becomes 0 and cur_version is unchanged.
- R10: If an active session sees no tx or rx handshake for WDOG_CYC cycles, it ends with done_fail and boot_sel 0.
- R11: key_we loads key_wdata only while the block is idle. A key write during a session has no effect on that session's tag check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an update session (taken in idle only) |
| key_we | input | 1 | Key write strobe |
| key_wdata | input | 2*TAG_W | Key value (write only) |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Server side accepts outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block accepts incoming byte |
| nvm_we | output | 1 | Storage write strobe |
| nvm_addr | output | $clog2(IMG_BYTES) | Storage byte address |
| nvm_data | output | 8 | Storage write data |
| nvm_ready | input | 1 | Storage can take a byte this cycle |
| cur_version | output | VER_W | Committed image version |
| boot_sel | output | 1 | 1 = updated image, 0 = default image |
| busy | output | 1 | Session in progress |
| done_ok | output | 1 | Pulse: update committed |
| done_fail | output | 1 | Pulse: session ended in fallback |

## Verification
While the image streams, two things happen on every accepted byte in one cycle: it is written to storage and absorbed by the MAC engine, and acceptance depends on both the storage ready and the engine ready. The bench provokes the overlap by driving nvm_ready from rotating stall patterns during the image. It also holds nvm_ready low through the header bytes, which must still pass. The overlap is judged on two counts: each stored byte must sit at its expected address, and the tag computed independently in the bench must be accepted exactly when it was left unaltered. A byte skipped or taken twice by either side would break one of the two.

// File: rtl/rupd_pkg.sv
package rupd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ANNOUNCE = 3'd1,
    ST_NONCE    = 3'd2,
    ST_RECEIVE  = 3'd3,
    ST_VERIFY   = 3'd4,
    ST_COMMIT   = 3'd5,
    ST_FALLBACK = 3'd6
  } rupd_state_e;

endpackage

// File: rtl/rupd_mac_stub.sv
// Behavioural keyed-MAC stand-in: rotate-left-by-one then add each byte,
// seeded from the low key half, finalised by XOR with the high key half.
module rupd_mac_stub #(
  parameter int TAG_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [2*TAG_W-1:0] key,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic [TAG_W-1:0]   tag
);

  logic [TAG_W-1:0] acc_q, acc_d;
  logic             rdy_q, rdy_d;

  always_comb begin
    acc_d = acc_q;
    rdy_d = 1'b1;
    if (clr) begin
      acc_d = key[TAG_W-1:0];
      rdy_d = 1'b0;
    end else if (in_valid && rdy_q) begin
      acc_d = {acc_q[TAG_W-2:0], acc_q[TAG_W-1]} + {{(TAG_W-8){1'b0}}, in_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rdy_q <= 1'b1;
    end else begin
      acc_q <= acc_d;
      rdy_q <= rdy_d;
    end
  end

  assign in_ready = rdy_q;
  assign tag      = acc_q ^ key[2*TAG_W-1:TAG_W];

endmodule

// File: rtl/rupd_tx_mux.sv
// Selects one byte of the outgoing header {fingerprint, version, nonce},
// most significant byte at index 0.
module rupd_tx_mux #(
  parameter int FP_W    = 32,
  parameter int VER_W   = 16,
  parameter int NONCE_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic [FP_W-1:0]    fp,
  input  logic [VER_W-1:0]   ver,
  input  logic [NONCE_W-1:0] nonce,
  input  logic [IDX_W-1:0]   idx,
  output logic [7:0]         byte_o
);

  localparam int HDR_W = FP_W + VER_W + NONCE_W;
  localparam int HDR_B = HDR_W / 8;

  logic [HDR_W-1:0] hdr;
  logic [7:0]       lanes [HDR_B];

  assign hdr = {fp, ver, nonce};

  for (genvar g = 0; g < HDR_B; g++) begin : g_lane
    assign lanes[g] = hdr[(HDR_B-1-g)*8 +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < HDR_B; i++) begin
      if (idx == IDX_W'(i)) byte_o = lanes[i];
    end
  end

endmodule

// File: rtl/rupd_wdog.sv
// Inactivity timer: raises expire when LIMIT-1 quiet cycles have passed.
module rupd_wdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic kick,
  output logic expire
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!active || kick) begin
      cnt_d = '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = active && !kick && (cnt_q >= CW'(LIMIT - 1));

endmodule

// File: rtl/remote_update_ctrl.sv
module remote_update_ctrl
  import rupd_pkg::*;
#(
  parameter int              FP_W        = 32,
  parameter logic [FP_W-1:0] FINGERPRINT = 32'hC0DE_5EED,
  parameter int              VER_W       = 16,
  parameter int              NONCE_W     = 32,
  parameter int              TAG_W       = 32,
  parameter int              IMG_BYTES   = 32,
  parameter int              WDOG_CYC    = 4096,
  localparam int             KEY_W       = 2 * TAG_W,
  localparam int             ADDR_W      = $clog2(IMG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              key_we,
  input  logic [KEY_W-1:0]  key_wdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              nvm_we,
  output logic [ADDR_W-1:0] nvm_addr,
  output logic [7:0]        nvm_data,
  input  logic              nvm_ready,
  output logic [VER_W-1:0]  cur_version,
  output logic              boot_sel,
  output logic              busy,
  output logic              done_ok,
  output logic              done_fail
);

  localparam int FP_B  = FP_W / 8;
  localparam int VER_B = VER_W / 8;
  localparam int NON_B = NONCE_W / 8;
  localparam int TAG_B = TAG_W / 8;
  localparam int ANN_B = FP_B + VER_B;
  localparam int TX_B  = ANN_B + NON_B;
  localparam int CNT_W = $clog2(TX_B + NON_B + 1);

  rupd_state_e        state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  img_q, img_d;
  logic [NONCE_W-1:0] dnonce_q;
  logic               dn_en;
  logic [VER_W-1:0]   nver_q, nver_d, nver_full;
  logic [TAG_W-9:0]   tsr_q, tsr_d;
  logic [TAG_W-1:0]   tag_full, mac_tag;
  logic [VER_W-1:0]   ver_q;
  logic               ver_en;
  logic               boot_q, boot_d, boot_en;
  logic [KEY_W-1:0]   key_q;
  logic               key_en;

  logic               mac_clr, mac_v, mac_rdy;
  logic [7:0]         mac_d, tx_byte;
  logic [CNT_W-1:0]   tx_idx;
  logic               tx_act, tx_hs, rx_hs;
  logic               snon_ph, nver_ph, img_ph, tag_ph;
  logic               wd_active, wd_expire;

  // ---------------------------------------------------------------- phases
  assign tx_act  = (state_q == ST_ANNOUNCE) ||
                   ((state_q == ST_NONCE) && (cnt_q < CNT_W'(NON_B)));
  assign snon_ph = (state_q == ST_NONCE) && (cnt_q >= CNT_W'(NON_B));
  assign nver_ph = (state_q == ST_RECEIVE) && (cnt_q < CNT_W'(VER_B));
  assign img_ph  = (state_q == ST_RECEIVE) && (cnt_q == CNT_W'(VER_B));
  assign tag_ph  = (state_q == ST_VERIFY);

  assign tx_idx  = (state_q == ST_NONCE) ? (cnt_q + CNT_W'(ANN_B)) : cnt_q;

  rupd_tx_mux #(
    .FP_W    (FP_W),
    .VER_W   (VER_W),
    .NONCE_W (NONCE_W),
    .IDX_W   (CNT_W)
  ) u_tx_mux (
    .fp     (FINGERPRINT),
    .ver    (ver_q),
    .nonce  (dnonce_q),
    .idx    (tx_idx),
    .byte_o (tx_byte)
  );

  // ------------------------------------------------------------ handshakes
  assign tx_valid = tx_act && mac_rdy;
  assign tx_data  = tx_byte;
  assign tx_hs    = tx_valid && tx_ready;

  assign rx_ready = ((snon_ph || nver_ph) && mac_rdy) ||
                    (img_ph && mac_rdy && nvm_ready) ||
                    tag_ph;
  assign rx_hs    = rx_valid && rx_ready;

  assign mac_v    = tx_hs || (rx_hs && !tag_ph);
  assign mac_d    = tx_hs ? tx_byte : rx_data;

  assign nvm_we   = img_ph && rx_hs;
  assign nvm_addr = img_q;
  assign nvm_data = rx_data;

  assign nver_full = {nver_q[VER_W-9:0], rx_data};
  assign tag_full  = {tsr_q, rx_data};

  // -------------------------------------------------------------- MAC engine
  rupd_mac_stub #(
    .TAG_W (TAG_W)
  ) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mac_clr),
    .key      (key_q),
    .in_valid (mac_v),
    .in_data  (mac_d),
    .in_ready (mac_rdy),
    .tag      (mac_tag)
  );

  // ---------------------------------------------------------------- watchdog
  assign wd_active = (state_q == ST_ANNOUNCE) || (state_q == ST_NONCE) ||
                     (state_q == ST_RECEIVE)  || (state_q == ST_VERIFY);

  rupd_wdog #(
    .LIMIT (WDOG_CYC)
  ) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (wd_active),
    .kick   (tx_hs || rx_hs),
    .expire (wd_expire)
  );

  // -------------------------------------------------------------- next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    img_d   = img_q;
    nver_d  = nver_q;
    tsr_d   = tsr_q;
    dn_en   = 1'b0;
    ver_en  = 1'b0;
    boot_en = 1'b0;
    boot_d  = boot_q;
    mac_clr = 1'b0;
    key_en  = (state_q == ST_IDLE) && key_we;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ANNOUNCE;
          cnt_d   = '0;
          dn_en   = 1'b1;
          mac_clr = 1'b1;
        end
      end
      ST_ANNOUNCE: begin
        if (tx_hs) begin
          if (cnt_q == CNT_W'(ANN_B - 1)) begin
            state_d = ST_NONCE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_NONCE: begin
        if (tx_hs || rx_hs) begin
          if (cnt_q == CNT_W'(2 * NON_B - 1)) begin
            state_d = ST_RECEIVE;
            cnt_d   = '0;
            img_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_RECEIVE: begin
        if (rx_hs) begin
          if (nver_ph) begin
            nver_d = nver_full;
            if (cnt_q == CNT_W'(VER_B - 1)) begin
              if (nver_full > ver_q) cnt_d = cnt_q + 1'b1;
              else                   state_d = ST_FALLBACK;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            img_d = img_q + 1'b1;
            if (img_q == ADDR_W'(IMG_BYTES - 1)) begin
              state_d = ST_VERIFY;
              cnt_d   = '0;
            end
          end
        end
      end
      ST_VERIFY: begin
        if (rx_hs) begin
          tsr_d = tag_full[TAG_W-9:0];
          if (cnt_q == CNT_W'(TAG_B - 1)) begin
            state_d = (tag_full == mac_tag) ? ST_COMMIT : ST_FALLBACK;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_COMMIT: begin
        ver_en  = 1'b1;
        boot_en = 1'b1;
        boot_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FALLBACK: begin
        boot_en = 1'b1;
        boot_d  = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (wd_expire) state_d = ST_FALLBACK;
  end

  // --------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      img_q   <= '0;
      nver_q  <= '0;
      tsr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      img_q   <= img_d;
      nver_q  <= nver_d;
      tsr_q   <= tsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dnonce_q <= '0;
    end else if (dn_en) begin
      dnonce_q <= dnonce_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ver_q <= '0;
    end else if (ver_en) begin
      ver_q <= nver_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b0;
    end else if (boot_en) begin
      boot_q <= boot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (key_en) begin
      key_q <= key_wdata;
    end
  end

  // ----------------------------------------------------------------- outputs
  assign cur_version = ver_q;
  assign boot_sel    = boot_q;
  assign busy        = (state_q != ST_IDLE);
  assign done_ok     = (state_q == ST_COMMIT);
  assign done_fail   = (state_q == ST_FALLBACK);

endmodule

// File: rtl/rupd_chk.sv
module rupd_chk #(
  parameter int VER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done_ok,
  input logic             done_fail,
  input logic             boot_sel,
  input logic             nvm_we,
  input logic             nvm_ready,
  input logic [VER_W-1:0] cur_version
);

  // R8
  ver_moves_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_version) |-> $past(done_ok));

  // R5
  ver_strictly_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_ok) |-> (cur_version > $past(cur_version)));

  // R8
  commit_boot_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> boot_sel);

  // R9
  fail_boot_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |=> !boot_sel);

  // R6
  nvm_write_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_we |-> nvm_ready);

  // R2
  session_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R10
  outcome_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_fail) |=> !busy);

endmodule

bind remote_update_ctrl rupd_chk #(.VER_W(VER_W)) u_rupd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done_ok     (done_ok),
  .done_fail   (done_fail),
  .boot_sel    (boot_sel),
  .nvm_we      (nvm_we),
  .nvm_ready   (nvm_ready),
  .cur_version (cur_version)
);

// File: tb/test_remote_update_ctrl.sv
module test_remote_update_ctrl;

  localparam int          IMGB = 8;
  localparam int          WDC  = 40;
  localparam logic [31:0] FP   = 32'hC0DE_5EED;
  localparam int          AW   = $clog2(IMGB);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, key_we;
  logic [63:0] key_wdata;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        nvm_we, nvm_ready;
  logic [AW-1:0] nvm_addr;
  logic [7:0]  nvm_data;
  logic [15:0] cur_version;
  logic        boot_sel, busy, done_ok, done_fail;

  remote_update_ctrl #(
    .FINGERPRINT (FP),
    .IMG_BYTES   (IMGB),
    .WDOG_CYC    (WDC)
  ) i_remote_update_ctrl (
    .clk (clk), .rst_n (rst_n), .start (start),
    .key_we (key_we), .key_wdata (key_wdata),
    .tx_valid (tx_valid), .tx_data (tx_data), .tx_ready (tx_ready),
    .rx_valid (rx_valid), .rx_data (rx_data), .rx_ready (rx_ready),
    .nvm_we (nvm_we), .nvm_addr (nvm_addr), .nvm_data (nvm_data),
    .nvm_ready (nvm_ready),
    .cur_version (cur_version), .boot_sel (boot_sel), .busy (busy),
    .done_ok (done_ok), .done_fail (done_fail)
  );

  always #10 clk = ~clk;

  int nvec = 0;
  int nmis = 0;

  // storage model and stall generator
  logic [7:0] nvm_img [IMGB];
  int         wr_total = 0;
  logic [7:0] stall_pat = 8'hFF;
  logic       force_low = 1'b0;
  int         ph = 0;

  always @(posedge clk) begin
    if (nvm_we) begin
      nvm_img[nvm_addr] = nvm_data;
      wr_total++;
    end
  end

  always @(negedge clk) begin
    nvm_ready <= force_low ? 1'b0 : stall_pat[ph % 8];
    ph <= ph + 1;
  end

  // reference state
  logic [15:0] m_ver   = 16'h0;
  logic        m_boot  = 1'b0;
  logic [31:0] m_nonce = 32'h0;
  logic [63:0] m_key   = 64'h0;

  // {new version, bad tag, stall pattern, seed}
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0005, 8'h00, 8'hFF, 8'h11},
    {16'h0005, 8'h00, 8'hFF, 8'h22},
    {16'h0003, 8'h00, 8'hFF, 8'h33},
    {16'h0009, 8'h01, 8'hA5, 8'h44},
    {16'h0009, 8'h00, 8'hA5, 8'h55},
    {16'h0100, 8'h00, 8'h36, 8'h66}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mstep(logic [31:0] a, logic [7:0] b);
    return {a[30:0], a[31]} + {24'h0, b};
  endfunction

  task automatic get_tx(output logic [7:0] b, output bit got);
    int w;
    got = 1'b0;
    b   = 8'h00;
    w   = 0;
    while (!got && w < 60) begin
      @(negedge clk); #1;
      if (tx_valid && tx_ready) begin
        b   = tx_data;
        got = 1'b1;
      end
      w++;
    end
  endtask

  task automatic put_rx(input logic [7:0] b, output bit took);
    int w;
    took = 1'b0;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    #1;
    w = 0;
    while (!rx_ready && w < 60) begin
      @(negedge clk); #1;
      w++;
    end
    if (rx_ready) begin
      @(posedge clk);
      took = 1'b1;
    end
    #1 rx_valid = 1'b0;
  endtask

  task automatic load_key(input logic [63:0] k);
    @(negedge clk);
    key_we    = 1'b1;
    key_wdata = k;
    @(negedge clk);
    key_we    = 1'b0;
    m_key     = k;
  endtask

  task automatic run_session(input logic [15:0] newv, input bit bad,
                             input logic [7:0] stall, input logic [7:0] seed,
                             input bit key_mid);
    logic [31:0] acc, tag, snon;
    logic [79:0] hdr;
    logic [7:0]  b;
    bit          got;
    int          base;
    acc  = m_key[31:0];
    base = wr_total;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    m_nonce = m_nonce + 1;
    hdr = {FP, m_ver, m_nonce};
    for (int i = 0; i < 10; i++) begin
      get_tx(b, got);
      if (i < 6) chk(got && b == hdr[79-8*i -: 8], "R2", "announce byte", b, hdr[79-8*i -: 8]);
      else       chk(got && b == hdr[79-8*i -: 8], "R3", "device nonce byte", b, hdr[79-8*i -: 8]);
      acc = mstep(acc, hdr[79-8*i -: 8]);
    end
    // header bytes must pass while storage is not ready
    force_low = 1'b1;
    snon = {seed, ~seed, seed ^ 8'h5A, 8'h3C};
    for (int i = 0; i < 4; i++) begin
      put_rx(snon[31-8*i -: 8], got);
      chk(got, "R4", "server nonce byte taken", got, 1);
      acc = mstep(acc, snon[31-8*i -: 8]);
    end
    for (int i = 0; i < 2; i++) begin
      put_rx(newv[15-8*i -: 8], got);
      chk(got, "R4", "new version byte taken", got, 1);
      acc = mstep(acc, newv[15-8*i -: 8]);
    end
    force_low = 1'b0;
    if (!(newv > m_ver)) begin
      @(negedge clk);
      chk(done_fail == 1'b1, "R5", "stale version done_fail", done_fail, 1);
      chk(wr_total == base, "R5", "no storage write", wr_total - base, 0);
      m_boot = 1'b0;
      @(negedge clk);
      chk(cur_version == m_ver, "R5", "version kept", cur_version, m_ver);
      chk(boot_sel == m_boot, "R5", "boot default", boot_sel, m_boot);
      return;
    end
    stall_pat = stall;
    if (key_mid) begin
      @(negedge clk);
      key_we    = 1'b1;
      key_wdata = ~m_key;
      @(negedge clk);
      key_we    = 1'b0;
    end
    for (int i = 0; i < IMGB; i++) begin
      b = seed + 8'(i * 7);
      put_rx(b, got);
      chk(got, "R6", "image byte taken", got, 1);
      acc = mstep(acc, b);
    end
    stall_pat = 8'hFF;
    tag = acc ^ m_key[63:32];
    if (bad) tag = tag ^ 32'h0000_0100;
    for (int i = 0; i < 4; i++) begin
      put_rx(tag[31-8*i -: 8], got);
    end
    @(negedge clk);
    if (bad) begin
      chk(done_fail == 1'b1 && done_ok == 1'b0, "R9", "mismatch outcome", {done_ok, done_fail}, 2'b01);
    end else begin
      chk(done_ok == 1'b1 && done_fail == 1'b0,
          key_mid ? "R11" : "R7", "tag match outcome", {done_ok, done_fail}, 2'b10);
    end
    chk(wr_total - base == IMGB, "R6", "write count", wr_total - base, IMGB);
    for (int i = 0; i < IMGB; i++) begin
      chk(nvm_img[i] == seed + 8'(i * 7), "R6", "stored byte", nvm_img[i], seed + 8'(i * 7));
    end
    if (!bad) begin
      m_ver  = newv;
      m_boot = 1'b1;
    end else begin
      m_boot = 1'b0;
    end
    @(negedge clk);
    chk(cur_version == m_ver, bad ? "R9" : "R8", "version after", cur_version, m_ver);
    chk(boot_sel == m_boot, bad ? "R9" : "R8", "boot after", boot_sel, m_boot);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++;
    nmis++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    bit         got;
    int         waited;
    rst_n = 1'b0; start = 1'b0; key_we = 1'b0; key_wdata = '0;
    tx_ready = 1'b1; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(cur_version == 16'h0, "R1", "cur_version", cur_version, 0);
    chk(boot_sel == 1'b0, "R1", "boot_sel", boot_sel, 0);
    chk({busy, tx_valid, rx_ready, nvm_we, done_ok, done_fail} == 6'b0,
        "R1", "idle outputs", {busy, tx_valid, rx_ready, nvm_we, done_ok, done_fail}, 0);

    load_key(64'h0123_4567_89AB_CDEF);

    for (int v = 0; v < NV; v++) begin
      run_session(VEC[v][39:24], VEC[v][23:16] != 8'h00, VEC[v][15:8], VEC[v][7:0], 1'b0);
    end

    // R10: server goes silent after the device nonce
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    m_nonce = m_nonce + 1;
    for (int i = 0; i < 10; i++) get_tx(b, got);
    waited = 0;
    while (!done_fail && waited < 4 * WDC) begin
      @(negedge clk); #1;
      waited++;
    end
    chk(done_fail && waited >= WDC - 3 && waited <= WDC + 3, "R10",
        "quiet cycles before fallback", waited, WDC);
    m_boot = 1'b0;
    @(negedge clk);
    chk(boot_sel == 1'b0, "R10", "boot default", boot_sel, 0);
    chk(cur_version == m_ver, "R10", "version kept", cur_version, m_ver);

    // R11: key write during a session is ignored
    run_session(16'h0200, 1'b0, 8'h5B, 8'h77, 1'b1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule